// File: doc/BRIEF.md
# Configurable DRAM Access Controller

This block turns host requests into DRAM strobe sequences on a 16-bit memory bus. A host presents a 28-bit address, a read/write flag, two byte enables and write data, and holds its request until the block returns a single-cycle acknowledge. The block then drives the row strobe, two byte strobes and a write strobe, along with an address that can be split into a row part and a column part. Read data is captured from the memory data bus at the end of the column cycle.

The upper byte of a 16-bit control word sets the behaviour. This byte is written through a one-cycle write port. It selects the byte-strobe scheme (two column strobes or two write strobes) and the precharge length. It chooses whether the row strobe stays low between accesses and whether page-mode bursts are used. It sets the column-strobe high-time duty, turns row/column multiplexing on or off, and sets the row shift, which is also the row-compare range. When the row strobe is held low and bursts are enabled, an access whose row matches the open row runs only a column cycle. Any other access first raises the row strobe, precharges, and then activates the new row.

Every access timing is counted in clocks. A column cycle lasts six clocks. The column strobe is high in its first three clocks in the 50% setting and in its first two clocks in the 35% setting, and is low for the rest of the cycle.

Top module: `dramc_top`

## Requirements
- R1: After synchronous reset, ras_n, cas_lo_n, byte_hi_n and we_lo_n are high, ack is low and cfg_rsvd is low. The control word is all zeros: two-column-strobe scheme, row strobe released, one-clock precharge, no bursts, 50% duty, no multiplexing, shift code 00.
- R2: A full access counts clocks from the edge that accepts the request. It runs the precharge clocks with ras_n high, then one activate clock with ras_n low, then a column cycle of six clocks with ras_n low. ack is high in the next clock.
- R3: Control bit 13 sets the precharge length: one clock at 0, two clocks at 1.
- R4: Control bit 11 sets the column-strobe high time within the six-clock column cycle: three high clocks then three low at 0, two high clocks then four low at 1. Strobes are high outside column cycles.
- R5: Control bit 15 selects the strobe scheme.
  - At 0, cas_lo_n and byte_hi_n are the column strobes for byte enables 0 and 1, and we_lo_n is low during the whole column cycle of a write.
  - At 1, cas_lo_n is the column strobe for both bytes. byte_hi_n and we_lo_n are low during the whole column cycle of a write, for byte enables 1 and 0.
- R6: Control bit 14 at 1 leaves ras_n low in idle after an access. At 0, ras_n returns high in the clock after the column cycle.
- R7: With bit 14 and bit 12 both at 1, an access whose row matches the open row skips precharge and activate, and its column cycle starts in the first clock. A row miss raises ras_n, precharges and activates the new row.
- R8: Control bits 9:8 set the row-compare range as address bits 27:8 (00), 27:9 (01) or 27:10 (10). This applies whether multiplexing is on or off.
- R9: Control bit 10 at 1 drives the address shifted right by 8, 9 or 10 (per bits 9:8) during precharge and activate, and the unshifted address during the column cycle. At 0, the unshifted address is driven throughout.
- R10: Shift code 11 acts as code 00. Writing it sets cfg_rsvd, which stays set until reset.
- R11: ack is high for exactly one clock per access. In that clock, rdata holds dq_in as sampled at the end of the column cycle. During a write's column cycle, dq_oe is high and dq_out carries the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word bits 15:8 |
| cfg_rsvd | output | 1 | Sticky flag: reserved shift code written |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address |
| req_ben | input | 2 | Byte enables (bit 1 high byte) |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock access completion |
| rdata | output | 16 | Read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe (or common column strobe), active low |
| byte_hi_n | output | 1 | High-byte column strobe or high-byte write strobe, active low |
| we_lo_n | output | 1 | Write strobe or low-byte write strobe, active low |
| mem_addr | output | 28 | Memory address (row or column phase) |
| dq_out | output | 16 | Memory write data |
| dq_oe | output | 1 | Memory data output enable |
| dq_in | input | 16 | Memory read data |

## Verification
The assertions check four properties on every clock:
- the column strobe is never low while the row strobe is high;
- acknowledge never lasts two clocks;
- write strobes appear only for write requests;
- the reserved-code flag never clears.

They also check that a row hit with the row held open enters the column cycle at once, that the row strobe stays low after an access in hold mode, and that a freshly latched row matches its own address. Only the scenarios can show the exact clock counts of precharge, activate and column phases, and the high/low split of the column strobe under each duty setting. The same holds for the byte routing of each strobe scheme, the shifted row address, and the row-compare boundaries at each shift code.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  // Positions inside the 16-bit control word; the write port carries bits 15:8.
  localparam int CFG_MSB    = 15;
  localparam int CFG_LSB    = 8;
  localparam int B_TWO_WE   = 15;
  localparam int B_RAS_HOLD = 14;
  localparam int B_PRE2     = 13;
  localparam int B_BURST    = 12;
  localparam int B_DUTY35   = 11;
  localparam int B_MUX      = 10;
  localparam int B_SHIFT_HI = 9;
  localparam int B_SHIFT_LO = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_COL  = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic       two_we;
    logic       ras_hold;
    logic       pre2;
    logic       burst;
    logic       duty35;
    logic       mux_en;
    logic [1:0] shift_code;
  } ctl_t;

endpackage

// File: rtl/dramc_cfg.sv
module dramc_cfg
  import dramc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CFG_MSB:CFG_LSB] wr_data,
  output ctl_t                   ctl,
  output logic                   rsvd_seen
);

  ctl_t ctl_q;
  logic rsvd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      rsvd_q <= 1'b0;
    end else if (wr_en) begin
      ctl_q.two_we     <= wr_data[B_TWO_WE];
      ctl_q.ras_hold   <= wr_data[B_RAS_HOLD];
      ctl_q.pre2       <= wr_data[B_PRE2];
      ctl_q.burst      <= wr_data[B_BURST];
      ctl_q.duty35     <= wr_data[B_DUTY35];
      ctl_q.mux_en     <= wr_data[B_MUX];
      ctl_q.shift_code <= wr_data[B_SHIFT_HI:B_SHIFT_LO];
      if (wr_data[B_SHIFT_HI:B_SHIFT_LO] == 2'b11) rsvd_q <= 1'b1;
    end
  end

  assign ctl       = ctl_q;
  assign rsvd_seen = rsvd_q;

  // R10
  rsvd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_q |=> rsvd_q);

endmodule

// File: rtl/dramc_addr.sv
module dramc_addr #(
  parameter int AW         = 28,
  parameter int SHIFT_BASE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    shift_code,
  input  logic [AW-1:0] acc_addr,
  input  logic          latch_row,
  output logic          row_hit,
  output logic [AW-1:0] row_addr
);

  localparam int NOPT = 3;

  logic [AW-1:0] open_q;
  logic          valid_q;
  logic [1:0]    sel;
  logic [NOPT-1:0] same_opt;
  logic [AW-1:0] row_opt [NOPT];

  // Reserved code 11 falls back to the narrowest shift.
  always_comb begin
    case (shift_code)
      2'b01:   sel = 2'd1;
      2'b10:   sel = 2'd2;
      default: sel = 2'd0;
    endcase
  end

  for (genvar g = 0; g < NOPT; g++) begin : g_opt
    assign same_opt[g] = ((acc_addr ^ open_q) >> (SHIFT_BASE + g)) == '0;
    assign row_opt[g]  = acc_addr >> (SHIFT_BASE + g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= '0;
      valid_q <= 1'b0;
    end else if (latch_row) begin
      open_q  <= acc_addr;
      valid_q <= 1'b1;
    end
  end

  assign row_hit  = valid_q && same_opt[sel];
  assign row_addr = row_opt[sel];

  // R8
  latch_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_row && !$isunknown(acc_addr)) |=> (row_hit || !$stable(acc_addr) || !$stable(shift_code)));

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int AW           = 28,
  parameter int DW           = 16,
  parameter int COL_PHASES   = 6,
  parameter int DUTY_LOW_PCT = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_ben,
  input  logic [DW-1:0] req_wdata,
  input  logic          row_hit,
  input  logic [AW-1:0] row_addr,
  output logic [AW-1:0] acc_addr,
  output logic          latch_row,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          ras_n,
  output logic          cas_lo_n,
  output logic          byte_hi_n,
  output logic          we_lo_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  localparam int CW      = (COL_PHASES > 2) ? $clog2(COL_PHASES) : 1;
  localparam int HI_HALF = COL_PHASES / 2;
  localparam int HI_LOW  = (COL_PHASES * DUTY_LOW_PCT + 50) / 100;
  localparam logic [CW-1:0] COL_LAST  = CW'(COL_PHASES - 1);
  localparam logic [CW-1:0] HI_HALF_C = CW'(HI_HALF);
  localparam logic [CW-1:0] HI_LOW_C  = CW'(HI_LOW);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          held_q, held_d;
  logic          ack_q, ack_d;
  logic          cap;
  logic          take;

  logic          we_q;
  logic [1:0]    ben_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic          cur_we;
  logic [1:0]    cur_ben;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  logic          ras_n_q, cl_q, bh_q, wl_q, oe_q;
  logic          ras_n_d, cl_d, bh_d, wl_d, oe_d;
  logic [AW-1:0] maddr_q, maddr_d;
  logic [DW-1:0] dqo_q, rdata_q;

  assign take      = (st_q == ST_IDLE) && req && !ack_q;
  assign cur_we    = take ? req_we    : we_q;
  assign cur_ben   = take ? req_ben   : ben_q;
  assign cur_addr  = take ? req_addr  : addr_q;
  assign cur_wdata = take ? req_wdata : wdata_q;
  assign acc_addr  = cur_addr;

  // Next-state sequencing.
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    held_d    = held_q && ctl.ras_hold;
    ack_d     = 1'b0;
    cap       = 1'b0;
    latch_row = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          cnt_d = '0;
          if (held_q && ctl.burst && row_hit) begin
            st_d = ST_COL;
          end else begin
            st_d   = ST_PRE;
            held_d = 1'b0;
          end
        end
      end
      ST_PRE: begin
        if (cnt_q == CW'(ctl.pre2)) begin
          st_d  = ST_ACT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACT: begin
        st_d      = ST_COL;
        cnt_d     = '0;
        latch_row = 1'b1;
      end
      default: begin
        if (cnt_q == COL_LAST) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          ack_d  = 1'b1;
          cap    = 1'b1;
          held_d = ctl.ras_hold;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // Pin values for the coming clock, taken from the next state so pins and state stay aligned.
  logic cas_on, wr_col;
  always_comb begin
    cas_on  = (st_d == ST_COL) && (cnt_d >= (ctl.duty35 ? HI_LOW_C : HI_HALF_C));
    wr_col  = (st_d == ST_COL) && cur_we;
    ras_n_d = (st_d == ST_PRE) || ((st_d == ST_IDLE) && !held_d);
    oe_d    = wr_col;
    if (ctl.two_we) begin
      cl_d = !cas_on;
      bh_d = !(wr_col && cur_ben[1]);
      wl_d = !(wr_col && cur_ben[0]);
    end else begin
      cl_d = !(cas_on && cur_ben[0]);
      bh_d = !(cas_on && cur_ben[1]);
      wl_d = !wr_col;
    end
    maddr_d = maddr_q;
    if (st_d == ST_COL)
      maddr_d = cur_addr;
    else if ((st_d == ST_PRE) || (st_d == ST_ACT))
      maddr_d = ctl.mux_en ? row_addr : cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      held_q  <= 1'b0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      ben_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      ras_n_q <= 1'b1;
      cl_q    <= 1'b1;
      bh_q    <= 1'b1;
      wl_q    <= 1'b1;
      oe_q    <= 1'b0;
      maddr_q <= '0;
      dqo_q   <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      held_q  <= held_d;
      ack_q   <= ack_d;
      ras_n_q <= ras_n_d;
      cl_q    <= cl_d;
      bh_q    <= bh_d;
      wl_q    <= wl_d;
      oe_q    <= oe_d;
      maddr_q <= maddr_d;
      dqo_q   <= cur_wdata;
      if (take) begin
        we_q    <= req_we;
        ben_q   <= req_ben;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap) rdata_q <= dq_in;
    end
  end

  assign ack       = ack_q;
  assign rdata     = rdata_q;
  assign ras_n     = ras_n_q;
  assign cas_lo_n  = cl_q;
  assign byte_hi_n = bh_q;
  assign we_lo_n   = wl_q;
  assign mem_addr  = maddr_q;
  assign dq_out    = dqo_q;
  assign dq_oe     = oe_q;

  // R4
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (!cl_q || (!ctl.two_we && !bh_q)) |-> !ras_n_q);

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

  // R5
  we_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wl_q |-> (we_q && oe_q));

  // R6
  hold_after_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_q && ctl.ras_hold) |-> !ras_n_q);

  // R7
  hit_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (take && held_q && ctl.burst && row_hit) |=> (!ras_n_q && (st_q == ST_COL)));

endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int AW           = 28,
  parameter int DW           = 16,
  parameter int COL_PHASES   = 6,
  parameter int DUTY_LOW_PCT = 35,
  parameter int SHIFT_BASE   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CFG_MSB:CFG_LSB] cfg_wdata,
  output logic                   cfg_rsvd,
  input  logic                   req,
  input  logic                   req_we,
  input  logic [AW-1:0]          req_addr,
  input  logic [1:0]             req_ben,
  input  logic [DW-1:0]          req_wdata,
  output logic                   ack,
  output logic [DW-1:0]          rdata,
  output logic                   ras_n,
  output logic                   cas_lo_n,
  output logic                   byte_hi_n,
  output logic                   we_lo_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          dq_out,
  output logic                   dq_oe,
  input  logic [DW-1:0]          dq_in
);

  ctl_t          ctl;
  logic          row_hit;
  logic [AW-1:0] row_addr;
  logic [AW-1:0] acc_addr;
  logic          latch_row;

  dramc_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .ctl       (ctl),
    .rsvd_seen (cfg_rsvd)
  );

  dramc_addr #(.AW(AW), .SHIFT_BASE(SHIFT_BASE)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .shift_code (ctl.shift_code),
    .acc_addr   (acc_addr),
    .latch_row  (latch_row),
    .row_hit    (row_hit),
    .row_addr   (row_addr)
  );

  dramc_seq #(
    .AW(AW), .DW(DW), .COL_PHASES(COL_PHASES), .DUTY_LOW_PCT(DUTY_LOW_PCT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .req       (req),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_ben   (req_ben),
    .req_wdata (req_wdata),
    .row_hit   (row_hit),
    .row_addr  (row_addr),
    .acc_addr  (acc_addr),
    .latch_row (latch_row),
    .ack       (ack),
    .rdata     (rdata),
    .ras_n     (ras_n),
    .cas_lo_n  (cas_lo_n),
    .byte_hi_n (byte_hi_n),
    .we_lo_n   (we_lo_n),
    .mem_addr  (mem_addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_in     (dq_in)
  );

endmodule

// File: tb/dramc_top_tb.sv
`timescale 1ns/1ps
module dramc_top_tb;

  // Column cycle: six clocks; column strobe high for 3 (50%) or 2 (35%) of them, then low.
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, cfg_we, cfg_rsvd, req, req_we, ack;
  logic [7:0]  cfg_wdata;
  logic [27:0] req_addr, mem_addr;
  logic [1:0]  req_ben;
  logic [15:0] req_wdata, rdata, dq_out, dq_in;
  logic        ras_n, cas_lo_n, byte_hi_n, we_lo_n, dq_oe;

  dramc_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rsvd(cfg_rsvd),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_ben(req_ben),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .byte_hi_n(byte_hi_n), .we_lo_n(we_lo_n),
    .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  logic        tr_ras [40];
  logic        tr_cl  [40];
  logic        tr_bh  [40];
  logic        tr_wl  [40];
  logic        tr_oe  [40];
  logic [27:0] tr_addr[40];
  logic [15:0] tr_dq  [40];
  int          tr_len;
  logic        idle_ras;
  logic [15:0] got_rdata;

  task automatic set_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_access(logic w, logic [1:0] b, logic [27:0] a, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; req_we = w; req_ben = b; req_addr = a; req_wdata = d;
    tr_len = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      tr_ras[i] = ras_n; tr_cl[i] = cas_lo_n; tr_bh[i] = byte_hi_n; tr_wl[i] = we_lo_n;
      tr_oe[i] = dq_oe; tr_addr[i] = mem_addr; tr_dq[i] = dq_out;
      if (ack) begin
        tr_len = i;
        got_rdata = rdata;
        break;
      end
    end
    req = 1'b0;
    @(negedge clk);
    idle_ras = ras_n;
  endtask

  task automatic check_access(string rq, bit hit, bit pre2, bit duty35, bit two_we, bit mux,
                              int sh, bit hold, logic w, logic [1:0] b, logic [27:0] a,
                              logic [15:0] d);
    int pre_n = pre2 ? 2 : 1;
    int base  = hit ? 0 : pre_n + 1;
    int hi    = duty35 ? 2 : 3;
    int bad_r = 0, bad_s = 0, bad_a = 0, bad_d = 0;
    chk(tr_len == base + 6, rq, "access length", tr_len, base + 6);
    if (tr_len == base + 6) begin
      for (int i = 0; i < base + 6; i++) begin
        logic e_ras, e_cl, e_bh, e_wl, e_oe, ca;
        logic [27:0] e_addr;
        if (!hit && i <= pre_n) begin
          e_ras = (i < pre_n); e_cl = 1; e_bh = 1; e_wl = 1; e_oe = 0;
          e_addr = mux ? (a >> sh) : a;
        end else begin
          ca = ((i - base) >= hi);
          e_ras = 0; e_oe = w; e_addr = a;
          if (two_we) begin
            e_cl = !ca; e_bh = !(w && b[1]); e_wl = !(w && b[0]);
          end else begin
            e_cl = !(ca && b[0]); e_bh = !(ca && b[1]); e_wl = !w;
          end
        end
        if (tr_ras[i] !== e_ras) bad_r++;
        if ({tr_cl[i], tr_bh[i], tr_wl[i]} !== {e_cl, e_bh, e_wl}) bad_s++;
        if (tr_addr[i] !== e_addr) bad_a++;
        if (tr_oe[i] !== e_oe || (e_oe && tr_dq[i] !== d)) bad_d++;
      end
    end
    chk(bad_r == 0, rq, "ras_n pattern mismatching clocks", bad_r, 0);
    chk(bad_s == 0, rq, "strobe pattern mismatching clocks", bad_s, 0);
    chk(bad_a == 0, rq, "mem_addr mismatching clocks", bad_a, 0);
    chk(bad_d == 0, rq, "write data/enable mismatching clocks", bad_d, 0);
    chk(idle_ras === !hold, rq, "ras_n level after access", idle_ras, !hold);
  endtask

  // Upper control byte bits: [7]=strobe scheme, [6]=ras hold, [5]=two-clock precharge,
  // [4]=burst, [3]=35% duty, [2]=multiplex, [1:0]=shift code.

  task automatic t_reset();
    chk(ras_n && cas_lo_n && byte_hi_n && we_lo_n, "R1", "strobes after reset",
        {ras_n, cas_lo_n, byte_hi_n, we_lo_n}, 4'hf);
    chk(!ack, "R1", "ack after reset", ack, 0);
    chk(!cfg_rsvd, "R1", "cfg_rsvd after reset", cfg_rsvd, 0);
    run_access(1, 2'b11, 28'h1234567, 16'hbeef);
    check_access("R1 R2 R4 R5", 0, 0, 0, 0, 0, 8, 0, 1, 2'b11, 28'h1234567, 16'hbeef);
  endtask

  task automatic t_read();
    dq_in = 16'h5a3c;
    run_access(0, 2'b01, 28'h0abcdef, 16'h0000);
    check_access("R2 R5 R11", 0, 0, 0, 0, 0, 8, 0, 0, 2'b01, 28'h0abcdef, 16'h0000);
    chk(got_rdata === 16'h5a3c, "R11", "rdata in ack clock", got_rdata, 16'h5a3c);
    chk(!ack, "R11", "ack after its clock", ack, 0);
  endtask

  task automatic t_pre2_duty35();
    set_cfg(8'h28);
    run_access(1, 2'b10, 28'h0000f00, 16'h1357);
    check_access("R3 R4", 0, 1, 1, 0, 0, 8, 0, 1, 2'b10, 28'h0000f00, 16'h1357);
  endtask

  task automatic t_two_we();
    set_cfg(8'h80);
    run_access(1, 2'b10, 28'h0200010, 16'h2468);
    check_access("R5 write", 0, 0, 0, 1, 0, 8, 0, 1, 2'b10, 28'h0200010, 16'h2468);
    run_access(0, 2'b11, 28'h0200012, 16'h0000);
    check_access("R5 read", 0, 0, 0, 1, 0, 8, 0, 0, 2'b11, 28'h0200012, 16'h0000);
  endtask

  task automatic t_mux();
    set_cfg(8'h05);
    run_access(1, 2'b11, 28'hfedcba9, 16'h0f0f);
    check_access("R9 shift9", 0, 0, 0, 0, 1, 9, 0, 1, 2'b11, 28'hfedcba9, 16'h0f0f);
    set_cfg(8'h06);
    run_access(0, 2'b11, 28'h7654321, 16'h0000);
    check_access("R9 shift10", 0, 0, 0, 0, 1, 10, 0, 0, 2'b11, 28'h7654321, 16'h0000);
  endtask

  task automatic t_burst();
    set_cfg(8'h50);
    run_access(1, 2'b11, 28'h0345600, 16'haaaa);
    check_access("R6 R7 first", 0, 0, 0, 0, 0, 8, 1, 1, 2'b11, 28'h0345600, 16'haaaa);
    run_access(0, 2'b11, 28'h03456fe, 16'h0000);
    check_access("R7 hit", 1, 0, 0, 0, 0, 8, 1, 0, 2'b11, 28'h03456fe, 16'h0000);
    run_access(1, 2'b01, 28'h0346600, 16'h5555);
    check_access("R7 miss", 0, 0, 0, 0, 0, 8, 1, 1, 2'b01, 28'h0346600, 16'h5555);
  endtask

  task automatic t_compare_range();
    set_cfg(8'h52);
    run_access(1, 2'b11, 28'h0004000, 16'h1111);
    check_access("R8 open", 0, 0, 0, 0, 0, 10, 1, 1, 2'b11, 28'h0004000, 16'h1111);
    run_access(1, 2'b11, 28'h0004200, 16'h2222);
    check_access("R8 bit9 inside row at code 10", 1, 0, 0, 0, 0, 10, 1, 1, 2'b11, 28'h0004200, 16'h2222);
    set_cfg(8'h50);
    run_access(1, 2'b11, 28'h0008000, 16'h3333);
    check_access("R8 open code 00", 0, 0, 0, 0, 0, 8, 1, 1, 2'b11, 28'h0008000, 16'h3333);
    run_access(1, 2'b11, 28'h0008200, 16'h4444);
    check_access("R8 bit9 outside row at code 00", 0, 0, 0, 0, 0, 8, 1, 1, 2'b11, 28'h0008200, 16'h4444);
  endtask

  task automatic t_release();
    set_cfg(8'h10);
    @(negedge clk);
    chk(ras_n === 1'b1, "R6", "ras_n released after hold cleared", ras_n, 1);
    run_access(0, 2'b11, 28'h0100000, 16'h0000);
    check_access("R6 released first", 0, 0, 0, 0, 0, 8, 0, 0, 2'b11, 28'h0100000, 16'h0000);
    run_access(0, 2'b11, 28'h0100002, 16'h0000);
    check_access("R6 same row still full", 0, 0, 0, 0, 0, 8, 0, 0, 2'b11, 28'h0100002, 16'h0000);
  endtask

  task automatic t_reserved();
    set_cfg(8'h07);
    chk(cfg_rsvd === 1'b1, "R10", "cfg_rsvd after code 11", cfg_rsvd, 1);
    run_access(1, 2'b11, 28'h9abcdef, 16'h7777);
    check_access("R10 code 11 as 00", 0, 0, 0, 0, 1, 8, 0, 1, 2'b11, 28'h9abcdef, 16'h7777);
    set_cfg(8'h00);
    chk(cfg_rsvd === 1'b1, "R10", "cfg_rsvd sticky", cfg_rsvd, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; req = 1'b0; req_we = 1'b0;
    req_addr = '0; req_ben = '0; req_wdata = '0; dq_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_pre2_duty35();
    t_two_we();
    t_mux();
    t_burst();
    t_compare_range();
    t_release();
    t_reserved();
    done = 1;
    summary();
    $finish;
  end

endmodule